// File: doc/BRIEF.md
# Timestamp Event Capture Unit

The unit keeps a 32-bit free-running time counter and records time-tagged events in a queue that software drains through a small word-addressed register port. Each event is a pair of words: the counter value at the moment of the event and a descriptor that says what happened. Events are raised by a software push command, by the counter wrapping and crossing its midpoint, by four external push pins, and by receive and transmit timestamp strobes from an Ethernet MAC.

Software reads the oldest event from the timestamp and descriptor registers and then writes the pop register to discard it. An interrupt line stays high while the queue holds at least one event, subject to an enable bit. A test bit can force it high. Events that arrive in the same clock are queued in ascending order of their type code. An event that finds no room is lost and sets a sticky overflow flag.

Top module: `tsq_unit`

## Requirements
- R1: After reset the counter is 0, the queue is empty, `irq` is low, the raw and masked status words read 0, and word 0 reads the `ID_VALUE` parameter.
- R2: While control bit 0 is set, the counter advances by one each clock. While it is clear, the counter holds its value.
- R3: Writing a word with bit 0 set to word 5 loads the counter with the value held in word 4. This works whether or not the unit is enabled.
- R4: Writing a word with bit 0 set to word 3 queues an event of type 0 that carries the counter value of that clock. The write is ignored while control bit 0 is clear.
- R5: Word 13 shows the oldest event's timestamp. Word 14 shows its descriptor: sequence ID in bits 15:0, message type in bits 19:16, event type in bits 23:20, and port or pin number in bits 28:24. Unused fields are zero.
- R6: When the counter wraps from all ones to zero, a type 1 event is queued with timestamp 0. When bit 31 goes from 0 to 1 while the unit is enabled, a type 2 event is queued with timestamp 0x80000000.
- R7: Each `hw_pin[i]` passes through a two-flop synchroniser, and each rising edge queues one type 3 event with pin number i+1. This happens only while control bit 8+i and bit 0 are both set. A pin held high yields a single event.
- R8: A pulse on `rx_stb` queues a type 4 event, and a pulse on `tx_stb` queues a type 5 event. Each event carries its own message type, sequence ID and port inputs. Strobes are ignored while the unit is disabled.
- R9: Events raised in the same clock carry the same timestamp and are queued in ascending type order.
- R10: The queue holds 16 events and returns them oldest first. Writing bit 0 to word 12 removes the oldest event. A pop on an empty queue has no effect.
- R11: An event that arrives while the queue is full is dropped, and raw status bit 1 becomes set and stays set until reset.
- R12: Raw status bit 0 (word 8) is "queue not empty" OR control bit 1. Masked status bit 0 (word 9) is raw bit 0 AND enable bit 0 (word 10). `irq` equals masked bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| hw_pin | input | NPIN | Asynchronous hardware push pins |
| rx_stb | input | 1 | Receive timestamp strobe |
| rx_msg | input | 4 | Receive message type |
| rx_seq | input | 16 | Receive sequence ID |
| rx_port | input | 5 | Receive port number |
| tx_stb | input | 1 | Transmit timestamp strobe |
| tx_msg | input | 4 | Transmit message type |
| tx_seq | input | 16 | Transmit sequence ID |
| tx_port | input | 5 | Transmit port number |
| irq | output | 1 | Event-pending interrupt |

## Verification
Software pushes are placed at known clock distances from a load. This separates correct counting, correct holding while disabled, and correct capture of the current value. The counter is also loaded just below the midpoint and just below the wrap, which isolates the two self-generated events and their fixed timestamps. A single clock that carries a push together with both Ethernet strobes distinguishes true ascending-type ordering from arrival order and checks that all three share one timestamp. Seventeen back-to-back pushes distinguish correct full-queue dropping from overwriting: sixteen consecutive timestamps must come back in order, followed by a sticky flag. Pin stimulus with only one pin enabled shows that the enables, the pin numbering and single-edge detection are each honoured.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
   localparam int TS_W   = 32;
   localparam int WORD_W = 32;

   typedef enum logic [3:0] {
      EV_SWPUSH = 4'd0,
      EV_ROLL   = 4'd1,
      EV_HALF   = 4'd2,
      EV_PIN    = 4'd3,
      EV_RX     = 4'd4,
      EV_TX     = 4'd5
   } ev_kind_e;

   typedef struct packed {
      logic [WORD_W-1:0] desc;
      logic [TS_W-1:0]   stamp;
   } ev_rec_t;

   localparam int REC_W = $bits(ev_rec_t);

   // word indices seen by software
   localparam logic [3:0] A_IDENT = 4'd0;
   localparam logic [3:0] A_CTRL  = 4'd1;
   localparam logic [3:0] A_PUSH  = 4'd3;
   localparam logic [3:0] A_LDVAL = 4'd4;
   localparam logic [3:0] A_LDEN  = 4'd5;
   localparam logic [3:0] A_RAW   = 4'd8;
   localparam logic [3:0] A_MSK   = 4'd9;
   localparam logic [3:0] A_IEN   = 4'd10;
   localparam logic [3:0] A_POP   = 4'd12;
   localparam logic [3:0] A_EVTS  = 4'd13;
   localparam logic [3:0] A_EVDS  = 4'd14;

   function automatic logic [WORD_W-1:0] make_desc(input logic [4:0] port,
                                                   input ev_kind_e kind,
                                                   input logic [3:0] msg,
                                                   input logic [15:0] seq);
      return {3'b000, port, 4'(kind), msg, seq};
   endfunction
endpackage

// File: rtl/tsq_counter.sv
module tsq_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] cnt,
   output logic [W-1:0] cnt_nxt,
   output logic         wrap_o,
   output logic         half_o
);
   if (W < 2) begin : g_bad_w
      $error("tsq_counter: W must be at least 2");
   end

   always_comb begin
      if (ld)       cnt_nxt = ld_val;
      else if (run) cnt_nxt = cnt + W'(1);
      else          cnt_nxt = cnt;
   end

   assign wrap_o = run && !ld && (&cnt);
   assign half_o = run && !cnt[W-1] && cnt_nxt[W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_nxt;
   end

   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !ld) |=> cnt == $past(cnt) + W'(1));
   a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> cnt == $past(ld_val));
endmodule

// File: rtl/tsq_pin_sync.sv
module tsq_pin_sync #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pin,
   input  logic [N-1:0] en,
   output logic [N-1:0] rise
);
   for (genvar i = 0; i < N; i++) begin : g_pin
      logic s1, s2, s3;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
         end else begin
            s1 <= pin[i];
            s2 <= s1;
            s3 <= s2;
         end
      end
      assign rise[i] = en[i] && s2 && !s3;

      a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
         rise[i] |=> !rise[i]);
   end
endmodule

// File: rtl/tsq_stage.sv
module tsq_stage
   import tsq_pkg::*;
#(
   parameter int NSRC = 9
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NSRC-1:0]      fire,
   input  ev_rec_t [NSRC-1:0]   rec_in,
   input  logic                 sink_full,
   output logic                 push_o,
   output ev_rec_t              rec_o,
   output logic                 drop_o
);
   logic [NSRC-1:0]    vld;
   logic [NSRC-1:0]    gnt;
   ev_rec_t [NSRC-1:0] hold;

   // lowest index (lowest type code) wins
   always_comb begin
      gnt = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (vld[i]) begin
            gnt    = '0;
            gnt[i] = 1'b1;
         end
      end
   end

   always_comb begin
      rec_o = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (gnt[i]) rec_o = hold[i];
      end
   end

   assign push_o = (|vld) && !sink_full;
   assign drop_o = ((|vld) && sink_full) || (|(fire & vld & ~gnt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= '0;
      end else begin
         for (int i = 0; i < NSRC; i++) begin
            if (fire[i])     vld[i] <= 1'b1;
            else if (gnt[i]) vld[i] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < NSRC; i++) begin
         if (fire[i]) hold[i] <= rec_in[i];
      end
   end

   a_r9_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   a_r9_head_first: assert property (@(posedge clk) disable iff (!rst_n)
      (vld[0] && !fire[0]) |=> !vld[0]);
endmodule

// File: rtl/tsq_fifo.sv
module tsq_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("tsq_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == (AW+1)'(DEPTH));
   assign do_pop  = pop && !empty;
   assign do_push = push && !full;
   assign dout    = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + AW'(1);
         if (do_pop)  rp <= rp + AW'(1);
         cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   a_r10_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> empty);
   a_r10_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= (AW+1)'(DEPTH));
endmodule

// File: rtl/tsq_unit.sv
module tsq_unit
   import tsq_pkg::*;
#(
   parameter int          NPIN       = 4,
   parameter int          FIFO_DEPTH = 16,
   parameter logic [31:0] ID_VALUE   = 32'h5A51_0100
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wen,
   input  logic [3:0]      reg_addr,
   input  logic [31:0]     reg_wdata,
   output logic [31:0]     reg_rdata,
   input  logic [NPIN-1:0] hw_pin,
   input  logic            rx_stb,
   input  logic [3:0]      rx_msg,
   input  logic [15:0]     rx_seq,
   input  logic [4:0]      rx_port,
   input  logic            tx_stb,
   input  logic [3:0]      tx_msg,
   input  logic [15:0]     tx_seq,
   input  logic [4:0]      tx_port,
   output logic            irq
);
   localparam int PIN_LSB = 8;
   localparam int IX_PIN0 = 3;
   localparam int IX_RX   = IX_PIN0 + NPIN;
   localparam int IX_TX   = IX_RX + 1;
   localparam int NSRC    = IX_TX + 1;

   if (NPIN < 1 || NPIN > 4) begin : g_bad_npin
      $error("tsq_unit: NPIN must be 1 to 4");
   end
   if (WORD_W != 32 || TS_W != 32) begin : g_bad_word
      $error("tsq_unit: register words must be 32 bits");
   end

   // configuration state
   logic            run_en, int_test, ien, ovf;
   logic [NPIN-1:0] pin_en;
   logic [TS_W-1:0] ld_val;

   logic wr_ctrl, push_req, load_req, pop_req;
   assign wr_ctrl  = reg_wen && (reg_addr == A_CTRL);
   assign push_req = reg_wen && (reg_addr == A_PUSH) && reg_wdata[0] && run_en;
   assign load_req = reg_wen && (reg_addr == A_LDEN) && reg_wdata[0];
   assign pop_req  = reg_wen && (reg_addr == A_POP)  && reg_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_en   <= 1'b0;
         int_test <= 1'b0;
         pin_en   <= '0;
         ld_val   <= '0;
         ien      <= 1'b0;
      end else if (reg_wen) begin
         if (wr_ctrl) begin
            run_en   <= reg_wdata[0];
            int_test <= reg_wdata[1];
            pin_en   <= reg_wdata[PIN_LSB +: NPIN];
         end
         if (reg_addr == A_LDVAL) ld_val <= reg_wdata;
         if (reg_addr == A_IEN)   ien    <= reg_wdata[0];
      end
   end

   // time base
   logic [TS_W-1:0] cnt, cnt_nxt;
   logic            wrap_ev, half_ev;

   tsq_counter #(.W(TS_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_en),
      .ld      (load_req),
      .ld_val  (ld_val),
      .cnt     (cnt),
      .cnt_nxt (cnt_nxt),
      .wrap_o  (wrap_ev),
      .half_o  (half_ev)
   );

   logic [NPIN-1:0] pin_rise;
   logic [NPIN-1:0] pin_gate;
   assign pin_gate = pin_en & {NPIN{run_en}};

   tsq_pin_sync #(.N(NPIN)) u_pins (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (hw_pin),
      .en    (pin_gate),
      .rise  (pin_rise)
   );

   // event sources, index order equals type order
   logic [NSRC-1:0]    src_fire;
   ev_rec_t [NSRC-1:0] src_rec;

   always_comb begin
      src_fire[0] = push_req;
      src_rec[0]  = '{desc: make_desc(5'd0, EV_SWPUSH, 4'd0, 16'd0), stamp: cnt};
      src_fire[1] = wrap_ev;
      src_rec[1]  = '{desc: make_desc(5'd0, EV_ROLL, 4'd0, 16'd0), stamp: cnt_nxt};
      src_fire[2] = half_ev;
      src_rec[2]  = '{desc: make_desc(5'd0, EV_HALF, 4'd0, 16'd0), stamp: cnt_nxt};
      for (int i = 0; i < NPIN; i++) begin
         src_fire[IX_PIN0+i] = pin_rise[i];
         src_rec[IX_PIN0+i]  = '{desc: make_desc(5'(i + 1), EV_PIN, 4'd0, 16'd0),
                                 stamp: cnt};
      end
      src_fire[IX_RX] = rx_stb && run_en;
      src_rec[IX_RX]  = '{desc: make_desc(rx_port, EV_RX, rx_msg, rx_seq), stamp: cnt};
      src_fire[IX_TX] = tx_stb && run_en;
      src_rec[IX_TX]  = '{desc: make_desc(tx_port, EV_TX, tx_msg, tx_seq), stamp: cnt};
   end

   logic    q_push, q_empty, q_full, stg_drop;
   ev_rec_t stg_rec, q_head;

   tsq_stage #(.NSRC(NSRC)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (src_fire),
      .rec_in    (src_rec),
      .sink_full (q_full),
      .push_o    (q_push),
      .rec_o     (stg_rec),
      .drop_o    (stg_drop)
   );

   tsq_fifo #(.DEPTH(FIFO_DEPTH), .W(REC_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (q_push),
      .din   (stg_rec),
      .pop   (pop_req),
      .dout  (q_head),
      .empty (q_empty),
      .full  (q_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ovf <= 1'b0;
      else if (stg_drop) ovf <= 1'b1;
   end

   // status and read-back
   logic [31:0] ctrl_word, raw_word, msk_word;

   always_comb begin
      ctrl_word                   = '0;
      ctrl_word[0]                = run_en;
      ctrl_word[1]                = int_test;
      ctrl_word[PIN_LSB +: NPIN]  = pin_en;
      raw_word                    = {30'd0, ovf, (!q_empty) || int_test};
      msk_word                    = {31'd0, raw_word[0] && ien};
   end

   assign irq = msk_word[0];

   always_comb begin
      unique case (reg_addr)
         A_IDENT: reg_rdata = ID_VALUE;
         A_CTRL:  reg_rdata = ctrl_word;
         A_LDVAL: reg_rdata = ld_val;
         A_RAW:   reg_rdata = raw_word;
         A_MSK:   reg_rdata = msk_word;
         A_IEN:   reg_rdata = {31'd0, ien};
         A_EVTS:  reg_rdata = q_head.stamp;
         A_EVDS:  reg_rdata = q_head.desc;
         default: reg_rdata = '0;
      endcase
   end

   a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
   a_r12_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !ien |-> !irq);
endmodule

// File: tb/sim_tsq_unit.sv
module sim_tsq_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wen = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  hw_pin = '0;
   logic        rx_stb = 1'b0, tx_stb = 1'b0;
   logic [3:0]  rx_msg = '0, tx_msg = '0;
   logic [15:0] rx_seq = '0, tx_seq = '0;
   logic [4:0]  rx_port = '0, tx_port = '0;
   logic        irq;

   int total = 0;
   int bad   = 0;

   localparam logic [31:0] IDV = 32'h5A51_0100;

   tsq_unit #(.NPIN(4), .FIFO_DEPTH(16), .ID_VALUE(IDV)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_pin(hw_pin),
      .rx_stb(rx_stb), .rx_msg(rx_msg), .rx_seq(rx_seq), .rx_port(rx_port),
      .tx_stb(tx_stb), .tx_msg(tx_msg), .tx_seq(tx_seq), .tx_port(tx_port),
      .irq(irq)
   );

   always #5 clk = ~clk;

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
      @(negedge clk);
      reg_wen = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic take(output logic [31:0] ts, output logic [31:0] ds);
      rd(4'd13, ts);
      rd(4'd14, ds);
      wr(4'd12, 32'h1);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(4'd0, d);  chk("R1 ident", d, IDV);
      rd(4'd8, d);  chk("R1 raw status", d, 32'h0);
      rd(4'd9, d);  chk("R1 masked status", d, 32'h0);
      chk("R1 irq", {31'd0, irq}, 32'h0);
   endtask

   task automatic t_count_load;
      logic [31:0] ts, ds, d;
      wr(4'd1, 32'h0);
      wr(4'd4, 32'h0000_1000);
      wr(4'd5, 32'h1);
      wr(4'd1, 32'h1);
      wr(4'd3, 32'h1);
      idle(5);
      wr(4'd3, 32'h1);
      wr(4'd1, 32'h0);
      idle(10);
      wr(4'd1, 32'h1);
      wr(4'd3, 32'h1);
      idle(3);
      take(ts, ds); chk("R3 loaded value captured", ts, 32'h0000_1000);
      chk("R5 push descriptor", ds, 32'h0);
      take(ts, ds); chk("R2 counts one per clock", ts, 32'h0000_1006);
      take(ts, ds); chk("R2 holds while disabled", ts, 32'h0000_1008);
      wr(4'd1, 32'h0);
      wr(4'd3, 32'h1);
      idle(3);
      rd(4'd8, d); chk("R4 push ignored when disabled", d, 32'h0);
      wr(4'd1, 32'h1);
   endtask

   task automatic t_half_roll;
      logic [31:0] ts, ds, d;
      wr(4'd1, 32'h0);
      wr(4'd4, 32'h7FFF_FFFE);
      wr(4'd5, 32'h1);
      wr(4'd1, 32'h1);
      idle(6);
      take(ts, ds);
      chk("R6 half timestamp", ts, 32'h8000_0000);
      chk("R6 half descriptor", ds, 32'h0020_0000);
      rd(4'd8, d); chk("R6 single half event", d, 32'h0);
      wr(4'd1, 32'h0);
      wr(4'd4, 32'hFFFF_FFFD);
      wr(4'd5, 32'h1);
      wr(4'd1, 32'h1);
      idle(6);
      take(ts, ds);
      chk("R6 wrap timestamp", ts, 32'h0);
      chk("R6 wrap descriptor", ds, 32'h0010_0000);
      rd(4'd8, d); chk("R6 single wrap event", d, 32'h0);
   endtask

   task automatic t_eth;
      logic [31:0] ts, ds, d;
      rx_msg = 4'h2; rx_seq = 16'hBEEF; rx_port = 5'd3;
      tx_msg = 4'h3; tx_seq = 16'h1234; tx_port = 5'd1;
      rx_stb = 1'b1; @(negedge clk); rx_stb = 1'b0;
      idle(3);
      take(ts, ds); chk("R8 rx descriptor", ds, 32'h0342_BEEF);
      tx_stb = 1'b1; @(negedge clk); tx_stb = 1'b0;
      idle(3);
      take(ts, ds); chk("R8 tx descriptor", ds, 32'h0153_1234);
      wr(4'd1, 32'h0);
      rx_stb = 1'b1; tx_stb = 1'b1; @(negedge clk); rx_stb = 1'b0; tx_stb = 1'b0;
      idle(3);
      rd(4'd8, d); chk("R8 strobes ignored when disabled", d, 32'h0);
      wr(4'd1, 32'h1);
   endtask

   task automatic t_order;
      logic [31:0] t0, t1, t2, d0, d1, d2;
      reg_addr = 4'd3; reg_wdata = 32'h1; reg_wen = 1'b1;
      rx_stb = 1'b1; tx_stb = 1'b1;
      @(negedge clk);
      reg_wen = 1'b0; rx_stb = 1'b0; tx_stb = 1'b0;
      idle(5);
      take(t0, d0); take(t1, d1); take(t2, d2);
      chk("R9 first is push", d0, 32'h0);
      chk("R9 second is rx", d1, 32'h0342_BEEF);
      chk("R9 third is tx", d2, 32'h0153_1234);
      chk("R9 shared stamp rx", t1, t0);
      chk("R9 shared stamp tx", t2, t0);
   endtask

   task automatic t_pins;
      logic [31:0] ts, ds, d;
      wr(4'd1, 32'h0000_0201);
      hw_pin = 4'b0011;
      idle(6);
      rd(4'd8, d); chk("R7 one pin event pending", d, 32'h1);
      take(ts, ds); chk("R7 enabled pin descriptor", ds, 32'h0230_0000);
      idle(5);
      rd(4'd8, d); chk("R7 held pin and masked pin quiet", d, 32'h0);
      hw_pin = 4'b0000;
      idle(4);
      wr(4'd1, 32'h1);
   endtask

   task automatic t_irq;
      logic [31:0] d, ts, ds;
      wr(4'd10, 32'h0);
      wr(4'd1, 32'h3);
      rd(4'd8, d); chk("R12 test bit raw", d, 32'h1);
      rd(4'd9, d); chk("R12 masked off", d, 32'h0);
      chk("R12 irq masked", {31'd0, irq}, 32'h0);
      wr(4'd10, 32'h1);
      chk("R12 irq forced", {31'd0, irq}, 32'h1);
      wr(4'd1, 32'h1);
      chk("R12 irq drops", {31'd0, irq}, 32'h0);
      wr(4'd3, 32'h1);
      idle(3);
      chk("R12 irq on pending", {31'd0, irq}, 32'h1);
      wr(4'd12, 32'h1);
      chk("R12 irq clears after pop", {31'd0, irq}, 32'h0);
      wr(4'd12, 32'h1);
      rd(4'd8, d); chk("R10 empty pop no effect", d, 32'h0);
      wr(4'd3, 32'h1);
      idle(3);
      rd(4'd8, d); chk("R10 queue usable after empty pop", d, 32'h1);
      take(ts, ds); chk("R10 entry after empty pop", ds, 32'h0);
      rd(4'd8, d); chk("R10 drained", d, 32'h0);
   endtask

   task automatic t_overflow;
      logic [31:0] d, ts, ds, first;
      for (int i = 0; i < 17; i++) wr(4'd3, 32'h1);
      idle(3);
      rd(4'd8, d); chk("R11 overflow and pending", d, 32'h3);
      take(first, ds);
      for (int i = 1; i < 16; i++) begin
         take(ts, ds);
         chk("R10 sixteen oldest first", ts, first + 32'(i));
      end
      rd(4'd8, d); chk("R11 seventeenth dropped, flag sticky", d, 32'h2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_count_load();
      t_half_roll();
      t_eth();
      t_order();
      t_pins();
      t_irq();
      t_overflow();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule